// File: doc/BRIEF.md
# Serial Bit-Clock Mode Detector and Generator

This block runs entirely on the master clock of an audio serial receiver. It times the word clock in master-clock cycles to tell whether the stream is at a base sample rate or a high one. It watches the shared bit-clock pin to decide whether an external bit clock is present. When no external bit clock is present, it builds one internally from the master clock, locked to the word clock. The receiver samples its serial data with the bit clock this block hands out, so the block also reports which source it picked, the measured ratio, and whether that ratio is legal.

The shared pin carries a second meaning. While the bit clock is generated inside, the pin is a static control level and is read as the upper de-emphasis select bit. The block decodes the de-emphasis request from the pin and a separate select input, following the active clock mode and rate. All inputs are assumed to be synchronous to the master clock. Each one passes through a single register stage before it is used.

Top module: `sclk_mode_unit`

## Requirements
- R1: The block counts master-clock cycles between successive rising word-clock edges and reports the committed count on `ratio_o`. A count of 128 or 192 sets `high_rate_o`. A count of 256, 384 or 512 clears it.
- R2: A new count is committed only when two consecutive word-clock periods measure the same value. Otherwise the previously committed ratio and mode flags hold.
- R3: Out of reset, and whenever the committed count is not one of the five legal values, `ratio_err_o` is 1, `high_rate_o` is 0 and the generated bit clock is held low. The reset state is `ratio_o`=0, `ext_bclk_o`=0, `bclk_o`=0 and `deemph_o`=0.
- R4: `ext_bclk_o` rises once 16 rising edges of the bit-clock pin occur within one word-clock phase, with the count restarting at each word-clock edge. A pin that toggles only 8 times per phase leaves the flag at 0.
- R5: `ext_bclk_o` falls after two consecutive full word-clock periods (rising edge to rising edge) contain no rising edge on the bit-clock pin.
- R6: The internal bit clock runs at 48 bit periods per word period when the ratio is 384 or 192. Otherwise it runs at 32 bit periods when `fmt_i` is 0 (I2S) or 3 (right-justified 16-bit), and at 64 bit periods when `fmt_i` is 1 (left-justified) or 2 (right-justified 24-bit).
- R7: The internal bit clock is high for exactly half of each bit period. After each rising word-clock edge it starts with its low half. At ratio 256 with format 0, `bclk_o` is low 3 and 6 cycles after the edge and high 7 cycles after it.
- R8: While `ext_bclk_o` is 1, `bclk_o` follows the bit-clock pin. Otherwise it carries the generated clock.
- R9: In internal mode at base rate, {bit-clock pin, `dem0_i`} decodes onto `deemph_o` as 00→0 (off), 01→1 (44.1 kHz), 10→2 (48 kHz), 11→3 (32 kHz).
- R10: In external mode, `dem0_i`=1 gives `deemph_o`=1 and `dem0_i`=0 gives 0. In high-rate mode `deemph_o` is 0 whatever the pins hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk_i | input | 1 | Word (left/right) clock |
| bclk_pin_i | input | 1 | Shared pin: external bit clock, or de-emphasis select bit 1 |
| dem0_i | input | 1 | De-emphasis select bit 0 |
| fmt_i | input | 2 | Serial format: 0 I2S, 1 left-justified, 2 right-justified 24-bit, 3 right-justified 16-bit |
| high_rate_o | output | 1 | High-rate mode flag |
| ext_bclk_o | output | 1 | External bit-clock mode flag |
| ratio_o | output | CNT_W | Committed master-to-word clock ratio |
| ratio_err_o | output | 1 | Committed ratio is not a legal value |
| bclk_o | output | 1 | Bit clock handed to the receiver |
| deemph_o | output | 2 | De-emphasis selection: 0 off, 1 44.1 kHz, 2 48 kHz, 3 32 kHz |

## Verification
A stale or wrong committed ratio shows at the ports within three word periods. It appears as a wrong `ratio_o`, a wrong rate flag, or a bit clock whose rising-edge count per word period differs from 32, 48 or 64. A phase counter that drifts from the word clock shows as a bit clock that is high instead of low a few cycles after the word-clock edge, or as a high-time count over one word period that is not half of it. A mode detector with a wrong edge or quiet count either fails to pass the external clock through within one word phase, or lets it go earlier or later than the second silent period.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'd0,
        FMT_LJ   = 2'd1,
        FMT_RJ24 = 2'd2,
        FMT_RJ16 = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        DEEMPH_OFF  = 2'd0,
        DEEMPH_44K1 = 2'd1,
        DEEMPH_48K  = 2'd2,
        DEEMPH_32K  = 2'd3
    } deemph_e;

endpackage

// File: rtl/sclk_ratio_meter.sv
module sclk_ratio_meter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk_rise_i,
    output logic [CNT_W-1:0] ratio_o,
    output logic             high_rate_o,
    output logic             ratio_err_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] last;
        logic             seen;
        logic             have_last;
        logic [CNT_W-1:0] ratio;
        logic             hr;
        logic             err;
    } meter_s;

    meter_s meter_q, meter_d;

    function automatic logic is_high(input logic [CNT_W-1:0] r);
        return (r == CNT_W'(128)) || (r == CNT_W'(192));
    endfunction

    function automatic logic is_base(input logic [CNT_W-1:0] r);
        return (r == CNT_W'(256)) || (r == CNT_W'(384)) || (r == CNT_W'(512));
    endfunction

    always_comb begin
        meter_d = meter_q;
        if (meter_q.cnt != CNT_MAX) begin
            meter_d.cnt = meter_q.cnt + 1'b1;
        end
        if (wclk_rise_i) begin
            meter_d.cnt  = CNT_W'(1);
            meter_d.seen = 1'b1;
            if (meter_q.seen) begin
                meter_d.last      = meter_q.cnt;
                meter_d.have_last = 1'b1;
                if (meter_q.have_last && (meter_q.cnt == meter_q.last)) begin
                    meter_d.ratio = meter_q.cnt;
                    meter_d.hr    = is_high(meter_q.cnt);
                    meter_d.err   = !is_high(meter_q.cnt) && !is_base(meter_q.cnt);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meter_q     <= '0;
            meter_q.err <= 1'b1;
        end else begin
            meter_q <= meter_d;
        end
    end

    assign ratio_o     = meter_q.ratio;
    assign high_rate_o = meter_q.hr;
    assign ratio_err_o = meter_q.err;

    // R2: the committed ratio only moves on a word-clock edge
    assert_commit_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (meter_q.ratio != $past(meter_q.ratio)) |-> $past(wclk_rise_i));

    // R1: high-rate flag implies a high-rate ratio and no error
    assert_high_rate_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        meter_q.hr |-> (!meter_q.err &&
                        ((meter_q.ratio == CNT_W'(128)) || (meter_q.ratio == CNT_W'(192)))));

endmodule

// File: rtl/sclk_ext_detect.sv
module sclk_ext_detect #(
    parameter int EDGE_LIMIT    = 16,
    parameter int QUIET_PERIODS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wclk_rise_i,
    input  logic wclk_fall_i,
    input  logic pin_rise_i,
    output logic ext_o
);

    localparam int EW = $clog2(EDGE_LIMIT + 1);
    localparam int QW = $clog2(QUIET_PERIODS + 1);
    localparam logic [EW-1:0] EDGE_TOP  = EW'(EDGE_LIMIT);
    localparam logic [QW-1:0] QUIET_TOP = QW'(QUIET_PERIODS);

    typedef struct packed {
        logic [EW-1:0] edges;
        logic [QW-1:0] quiet;
        logic          active;
        logic          ext;
    } det_s;

    det_s det_q, det_d;

    always_comb begin
        det_d = det_q;

        // edges seen within the current word-clock phase
        if (wclk_rise_i || wclk_fall_i) begin
            det_d.edges = pin_rise_i ? EW'(1) : '0;
        end else if (pin_rise_i && (det_q.edges != EDGE_TOP)) begin
            det_d.edges = det_q.edges + 1'b1;
        end

        // silent whole word periods
        if (wclk_rise_i) begin
            if (det_q.active || pin_rise_i) begin
                det_d.quiet = '0;
            end else if (det_q.quiet != QUIET_TOP) begin
                det_d.quiet = det_q.quiet + 1'b1;
            end
            det_d.active = 1'b0;
        end else if (pin_rise_i) begin
            det_d.active = 1'b1;
        end

        if (pin_rise_i && (det_d.edges == EDGE_TOP)) begin
            det_d.ext   = 1'b1;
            det_d.quiet = '0;
        end else if (det_d.quiet == QUIET_TOP) begin
            det_d.ext = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign ext_o = det_q.ext;

    // R4: external mode is only entered on a pin edge
    assert_enter_on_pin_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_q.ext) |-> $past(pin_rise_i));

    // R5: external mode is only left at a word-clock period boundary
    assert_leave_on_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det_q.ext) |-> $past(wclk_rise_i));

endmodule

// File: rtl/sclk_bclk_gen.sv
module sclk_bclk_gen
    import sclk_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk_rise_i,
    input  logic [CNT_W-1:0] ratio_i,
    input  logic             ratio_err_i,
    input  logic [1:0]       fmt_i,
    output logic             bclk_o
);

    typedef struct packed {
        logic [CNT_W-1:0] ph;
        logic             bclk;
    } gen_s;

    gen_s gen_q, gen_d;

    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] ph_last;
    logic             idle;

    // master clocks per half bit period
    function automatic logic [CNT_W-1:0] half_of(input logic [CNT_W-1:0] r,
                                                 input fmt_e f);
        if (r == CNT_W'(384)) return CNT_W'(4);
        if (r == CNT_W'(192)) return CNT_W'(2);
        if ((f == FMT_I2S) || (f == FMT_RJ16)) return r >> 6;
        return r >> 7;
    endfunction

    always_comb begin
        half    = half_of(ratio_i, fmt_e'(fmt_i));
        ph_last = (half << 1) - 1'b1;
        idle    = ratio_err_i || (half == '0);
        gen_d   = gen_q;
        if (idle) begin
            gen_d.ph = '0;
        end else if (wclk_rise_i || (gen_q.ph >= ph_last)) begin
            gen_d.ph = '0;
        end else begin
            gen_d.ph = gen_q.ph + 1'b1;
        end
        gen_d.bclk = !idle && (gen_d.ph >= half);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign bclk_o = gen_q.bclk;

    // R3: an illegal ratio keeps the generated clock low
    assert_idle_on_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_err_i |=> !gen_q.bclk);

    // R7: each word-clock edge starts the low half of a bit period
    assert_low_after_word_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wclk_rise_i |=> !gen_q.bclk);

endmodule

// File: rtl/sclk_mode_unit.sv
module sclk_mode_unit
    import sclk_pkg::*;
#(
    parameter int CNT_W         = 10,
    parameter int EDGE_LIMIT    = 16,
    parameter int QUIET_PERIODS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk_i,
    input  logic             bclk_pin_i,
    input  logic             dem0_i,
    input  logic [1:0]       fmt_i,
    output logic             high_rate_o,
    output logic             ext_bclk_o,
    output logic [CNT_W-1:0] ratio_o,
    output logic             ratio_err_o,
    output logic             bclk_o,
    output logic [1:0]       deemph_o
);

    typedef struct packed {
        logic    wclk;
        logic    wclk_p;
        logic    pin;
        logic    pin_p;
        logic    dem0;
        logic    bclk_out;
        deemph_e deemph;
    } top_s;

    top_s top_q, top_d;

    logic             wclk_rise;
    logic             wclk_fall;
    logic             pin_rise;
    logic             hr;
    logic             err;
    logic             ext;
    logic             gen_bclk;
    logic [CNT_W-1:0] ratio;

    assign wclk_rise = top_q.wclk && !top_q.wclk_p;
    assign wclk_fall = !top_q.wclk && top_q.wclk_p;
    assign pin_rise  = top_q.pin && !top_q.pin_p;

    sclk_ratio_meter #(.CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .wclk_rise_i (wclk_rise),
        .ratio_o     (ratio),
        .high_rate_o (hr),
        .ratio_err_o (err)
    );

    sclk_ext_detect #(
        .EDGE_LIMIT    (EDGE_LIMIT),
        .QUIET_PERIODS (QUIET_PERIODS)
    ) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .wclk_rise_i (wclk_rise),
        .wclk_fall_i (wclk_fall),
        .pin_rise_i  (pin_rise),
        .ext_o       (ext)
    );

    sclk_bclk_gen #(.CNT_W(CNT_W)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .wclk_rise_i (wclk_rise),
        .ratio_i     (ratio),
        .ratio_err_i (err),
        .fmt_i       (fmt_i),
        .bclk_o      (gen_bclk)
    );

    always_comb begin
        top_d          = top_q;
        top_d.wclk     = wclk_i;
        top_d.wclk_p   = top_q.wclk;
        top_d.pin      = bclk_pin_i;
        top_d.pin_p    = top_q.pin;
        top_d.dem0     = dem0_i;
        top_d.bclk_out = ext ? top_q.pin : gen_bclk;
        if (hr) begin
            top_d.deemph = DEEMPH_OFF;
        end else if (ext) begin
            top_d.deemph = top_q.dem0 ? DEEMPH_44K1 : DEEMPH_OFF;
        end else begin
            unique case ({top_q.pin, top_q.dem0})
                2'b00:   top_d.deemph = DEEMPH_OFF;
                2'b01:   top_d.deemph = DEEMPH_44K1;
                2'b10:   top_d.deemph = DEEMPH_48K;
                default: top_d.deemph = DEEMPH_32K;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign high_rate_o = hr;
    assign ext_bclk_o  = ext;
    assign ratio_o     = ratio;
    assign ratio_err_o = err;
    assign bclk_o      = top_q.bclk_out;
    assign deemph_o    = top_q.deemph;

    // R10: high-rate mode never carries a de-emphasis selection
    assert_high_rate_no_deemph_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hr) |-> (top_q.deemph == DEEMPH_OFF));

    // R8: in external mode the output bit clock tracks the pin
    assert_ext_passthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ext) && $past(rst_n)) |-> (top_q.bclk_out == $past(top_q.pin)));

endmodule

// File: tb/sclk_mode_unit_test.sv
module sclk_mode_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks   = 0;
    int failures = 0;

    // stimulus state
    int   wper_a  = 256;
    int   wper_b  = 256;
    int   wcur    = 256;
    int   wcnt    = 0;
    bit   alt_sel = 1'b0;
    int   bper    = 0;
    int   bcnt    = 0;
    logic dem1_val = 1'b0;
    logic dem0     = 1'b0;
    logic [1:0] fmt = 2'd0;

    logic wclk;
    logic bclk_pin;

    always @(negedge clk) begin
        if (wcnt >= wcur - 1) begin
            wcnt    <= 0;
            alt_sel <= ~alt_sel;
            wcur    <= alt_sel ? wper_a : wper_b;
        end else begin
            wcnt <= wcnt + 1;
        end
        if (bper > 0) begin
            if (bcnt >= bper - 1) bcnt <= 0;
            else                  bcnt <= bcnt + 1;
        end else begin
            bcnt <= 0;
        end
    end

    assign wclk     = (wcnt < wcur / 2);
    assign bclk_pin = (bper > 0) ? (bcnt >= bper / 2) : dem1_val;

    logic             high_rate;
    logic             ext_bclk;
    logic [CNT_W-1:0] ratio;
    logic             ratio_err;
    logic             bclk;
    logic [1:0]       deemph;

    sclk_mode_unit #(.CNT_W(CNT_W)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wclk_i      (wclk),
        .bclk_pin_i  (bclk_pin),
        .dem0_i      (dem0),
        .fmt_i       (fmt),
        .high_rate_o (high_rate),
        .ext_bclk_o  (ext_bclk),
        .ratio_o     (ratio),
        .ratio_err_o (ratio_err),
        .bclk_o      (bclk),
        .deemph_o    (deemph)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_wcnt(input int k);
        do begin
            @(negedge clk);
            #1;
        end while (wcnt != k);
    endtask

    task automatic set_ratio(input int r);
        wper_a = r;
        wper_b = r;
        step(600 + 4 * r);
    endtask

    task automatic window(input int n, output int rises, output int highs);
        logic prev;
        rises = 0;
        highs = 0;
        step(1);
        prev = bclk;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (bclk && !prev) rises++;
            if (bclk) highs++;
            prev = bclk;
        end
    endtask

    task automatic t_reset;
        step(3);
        check("R3 reset ratio_err", int'(ratio_err), 1);
        check("R3 reset high_rate", int'(high_rate), 0);
        check("R3 reset ext_bclk", int'(ext_bclk), 0);
        check("R3 reset bclk", int'(bclk), 0);
        check("R3 reset ratio", int'(ratio), 0);
        check("R3 reset deemph", int'(deemph), 0);
    endtask

    task automatic t_rate(input int r, input logic [1:0] f, input int exp_hr, input int exp_bits);
        int rises, highs;
        fmt = f;
        set_ratio(r);
        check($sformatf("R1 ratio value r=%0d", r), int'(ratio), r);
        check($sformatf("R1 rate flag r=%0d", r), int'(high_rate), exp_hr);
        check($sformatf("R3 no error r=%0d", r), int'(ratio_err), 0);
        window(r, rises, highs);
        check($sformatf("R6 bit periods r=%0d fmt=%0d", r, f), rises, exp_bits);
        check($sformatf("R7 duty r=%0d fmt=%0d", r, f), highs, r / 2);
    endtask

    task automatic t_align;
        fmt = 2'd0;
        set_ratio(256);
        wait_wcnt(3);
        check("R7 low 3 cycles after word edge", int'(bclk), 0);
        wait_wcnt(6);
        check("R7 low 6 cycles after word edge", int'(bclk), 0);
        wait_wcnt(7);
        check("R7 high 7 cycles after word edge", int'(bclk), 1);
    endtask

    task automatic t_hold;
        fmt = 2'd0;
        set_ratio(256);
        wper_a = 256;
        wper_b = 384;
        step(3000);
        check("R2 alternating periods hold ratio", int'(ratio), 256);
        check("R2 alternating periods hold error", int'(ratio_err), 0);
        set_ratio(384);
        check("R2 repeated period commits", int'(ratio), 384);
    endtask

    task automatic t_bad;
        int rises, highs;
        set_ratio(300);
        check("R3 illegal ratio error", int'(ratio_err), 1);
        check("R3 illegal ratio not high rate", int'(high_rate), 0);
        check("R1 illegal ratio reported", int'(ratio), 300);
        window(600, rises, highs);
        check("R3 illegal ratio bclk idle", highs, 0);
    endtask

    task automatic t_ext;
        int rises, highs;
        fmt = 2'd0;
        set_ratio(256);
        bper = 16;
        step(3 * 256);
        check("R4 eight edges per phase stay internal", int'(ext_bclk), 0);
        bper = 4;
        step(3 * 256);
        check("R4 many edges enter external", int'(ext_bclk), 1);
        window(256, rises, highs);
        check("R8 external clock passed through", rises, 64);
        dem0 = 1'b1;
        step(5);
        check("R10 external dem0=1", int'(deemph), 1);
        dem0 = 1'b0;
        step(5);
        check("R10 external dem0=0", int'(deemph), 0);
        wait_wcnt(1);
        bper     = 0;
        dem1_val = 1'b0;
        step(384);
        check("R5 one silent period keeps external", int'(ext_bclk), 1);
        step(512);
        check("R5 two silent periods leave external", int'(ext_bclk), 0);
    endtask

    task automatic t_deemph;
        fmt = 2'd0;
        bper = 0;
        set_ratio(256);
        for (int v = 0; v < 4; v++) begin
            dem1_val = v[1];
            dem0     = v[0];
            step(6);
            check($sformatf("R9 internal decode %0d", v), int'(deemph), v);
        end
        dem1_val = 1'b1;
        dem0     = 1'b1;
        set_ratio(128);
        check("R10 high rate flag", int'(high_rate), 1);
        check("R10 high rate forces off", int'(deemph), 0);
        dem1_val = 1'b0;
        dem0     = 1'b0;
    endtask

    initial begin
        step(5);
        rst_n = 1'b1;
        t_reset();
        t_rate(256, 2'd0, 0, 32);
        t_rate(384, 2'd1, 0, 48);
        t_rate(192, 2'd3, 1, 48);
        t_rate(128, 2'd1, 1, 64);
        t_rate(512, 2'd3, 0, 32);
        t_rate(256, 2'd2, 0, 64);
        t_align();
        t_hold();
        t_bad();
        t_ext();
        t_deemph();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule